// File: doc/BRIEF.md
# Segment-Encoded Message Sequencer

This block shows a fixed two-word text message on one seven-segment digit, one character at a time. Each high cycle of an advance strobe moves it to the next character. The strobe typically comes from a slow external timer that pulses once per display interval. The message is "PLAnE" and "bOArd" with a space between them. A build parameter can add a second space at the end, so the two words stay apart when the message starts over.

The state register needs no decoder. Seven of its flip-flops hold the lit-segment pattern of the current glyph, and the segment pins come straight from them. An eighth flip-flop records which word the glyph belongs to. This bit tells apart glyphs that occur twice: the letter A is in both words, and the blank occurs twice when the trailing space is enabled. The same bit drives a red indicator for the first word and a blue one for the second. The next state comes from a hard-coded table indexed by all eight state bits. Any code that is not in the message leads back to the first character.

Top module: `glyph_ticker`

## Requirements
- R1: `seg` is active-high, with seg[0] driving segment a, seg[1] b, and so on up to seg[6] driving g. The glyph codes (hex) are P=73, L=38, A=77, n=54, E=79, blank=00, b=7C, o=5C, r=50, d=5E. The display shows them in the order P, L, A, n, E, blank, b, o, A, r, d, then the optional trailing blank.
- R2: A high `rst` at a rising clock edge loads the first character, P, with the red LED lit and the blue LED dark. Reset takes priority over `adv`.
- R3: The displayed character changes only at a rising edge where `adv` is high and `rst` is low. When `adv` is low, the segments and LEDs keep their values.
- R4: The two occurrences of A have different successors. The A in the first word is followed by n, and the A in the second word is followed by r.
- R5: `led_red` is lit for P, L, A, n, E and the blank between the words. `led_blue` is lit for b, o, A, r, d and the trailing blank. Exactly one of the two is lit at any time.
- R6: After the last position, an advance returns the display to P. With TRAIL_SPACE=1 the cycle has 12 positions and ends with a blank shown with the blue LED. With TRAIL_SPACE=0 it has 11 positions and ends with d.
- R7: The pair of segment code and LED state is always one of the legal positions of the configured message. Any other state code goes to P on the next advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| adv | input | 1 | Advance strobe; moves to the next character when high at a clock edge |
| seg | output | 7 | Segment lines a..g, active high, bit 0 = a |
| led_red | output | 1 | Lit while a first-word position is shown |
| led_blue | output | 1 | Lit while a second-word position is shown |

## Verification
The bench targets the repeated A. A design that keyed its successor on the segment pattern alone would send the second-word A to n, or the first-word A to r, and show the wrong letters from then on. It also checks the end of the message in both the 11-position and 12-position builds. An off-by-one at the wrap would skip the trailing blank or land on a blank with the red LED lit. Long runs with `adv` low, and a reset applied in the middle of the message, show whether the design moves on edges without a strobe or lets a reset lose to a simultaneous advance.

// File: rtl/glyph_ticker.sv
module glyph_ticker #(
  parameter bit TRAIL_SPACE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       adv,
  output logic [6:0] seg,
  output logic       led_red,
  output logic       led_blue
);

  localparam logic [6:0] G_P  = 7'h73;
  localparam logic [6:0] G_L  = 7'h38;
  localparam logic [6:0] G_A  = 7'h77;
  localparam logic [6:0] G_N  = 7'h54;
  localparam logic [6:0] G_E  = 7'h79;
  localparam logic [6:0] G_SP = 7'h00;
  localparam logic [6:0] G_B  = 7'h7C;
  localparam logic [6:0] G_O  = 7'h5C;
  localparam logic [6:0] G_R  = 7'h50;
  localparam logic [6:0] G_D  = 7'h5E;
  localparam logic [7:0] S_FIRST = {1'b0, G_P};

  logic [7:0] state, state_nxt;

  function automatic logic [7:0] next_of(input logic [7:0] s);
    case (s)
      {1'b0, G_P}:  next_of = {1'b0, G_L};
      {1'b0, G_L}:  next_of = {1'b0, G_A};
      {1'b0, G_A}:  next_of = {1'b0, G_N};
      {1'b0, G_N}:  next_of = {1'b0, G_E};
      {1'b0, G_E}:  next_of = {1'b0, G_SP};
      {1'b0, G_SP}: next_of = {1'b1, G_B};
      {1'b1, G_B}:  next_of = {1'b1, G_O};
      {1'b1, G_O}:  next_of = {1'b1, G_A};
      {1'b1, G_A}:  next_of = {1'b1, G_R};
      {1'b1, G_R}:  next_of = {1'b1, G_D};
      {1'b1, G_D}:  next_of = TRAIL_SPACE ? {1'b1, G_SP} : S_FIRST;
      default:      next_of = S_FIRST;
    endcase
  endfunction

  assign state_nxt = next_of(state);

  always_ff @(posedge clk) begin
    if (rst)      state <= S_FIRST;
    else if (adv) state <= state_nxt;
  end

  assign seg      = state[6:0];
  assign led_red  = ~state[7];
  assign led_blue = state[7];

endmodule

// File: rtl/glyph_ticker_chk.sv
module glyph_ticker_chk #(
  parameter bit TRAIL_SPACE = 1'b1
) (
  input logic       clk,
  input logic       rst,
  input logic       adv,
  input logic [6:0] seg,
  input logic       led_red,
  input logic       led_blue
);

  localparam logic [7:0] LAST = TRAIL_SPACE ? 8'h80 : 8'hDE;

  function automatic logic legal(input logic w, input logic [6:0] s);
    if (!w) legal = (s == 7'h73) || (s == 7'h38) || (s == 7'h77) ||
                    (s == 7'h54) || (s == 7'h79) || (s == 7'h00);
    else    legal = (s == 7'h7C) || (s == 7'h5C) || (s == 7'h77) ||
                    (s == 7'h50) || (s == 7'h5E) || (TRAIL_SPACE && s == 7'h00);
  endfunction

  p_reset_r2: assert property (@(posedge clk)
    rst |=> (seg == 7'h73 && led_red && !led_blue));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(seg) && $stable(led_red) && $stable(led_blue)));

  p_first_a_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && led_red && seg == 7'h77) |=> (seg == 7'h54 && led_red));

  p_second_a_r4: assert property (@(posedge clk) disable iff (rst)
    (adv && led_blue && seg == 7'h77) |=> (seg == 7'h50 && led_blue));

  p_leds_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot({led_red, led_blue}));

  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (adv && {led_blue, seg} == LAST) |=> (seg == 7'h73 && led_red));

  p_legal_r7: assert property (@(posedge clk) disable iff (rst)
    legal(led_blue, seg));

endmodule

bind glyph_ticker glyph_ticker_chk #(.TRAIL_SPACE(TRAIL_SPACE)) i_chk (
  .clk(clk), .rst(rst), .adv(adv), .seg(seg),
  .led_red(led_red), .led_blue(led_blue)
);

// File: tb/test_glyph_ticker.sv
module test_glyph_ticker;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic adv = 1'b0;
  logic [6:0] seg_l, seg_s;
  logic red_l, blue_l, red_s, blue_s;
  int checks = 0;
  int failures = 0;
  int pos_l = 0;
  int pos_s = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  glyph_ticker #(.TRAIL_SPACE(1'b1)) i_glyph_ticker (
    .clk(clk), .rst(rst), .adv(adv), .seg(seg_l), .led_red(red_l), .led_blue(blue_l));

  glyph_ticker #(.TRAIL_SPACE(1'b0)) i_glyph_ticker_short (
    .clk(clk), .rst(rst), .adv(adv), .seg(seg_s), .led_red(red_s), .led_blue(blue_s));

  // {word bit, segments} expected at each message position
  function automatic logic [7:0] exp_at(input int p);
    case (p)
      0: exp_at = 8'h73;  1: exp_at = 8'h38;  2: exp_at = 8'h77;
      3: exp_at = 8'h54;  4: exp_at = 8'h79;  5: exp_at = 8'h00;
      6: exp_at = 8'hFC;  7: exp_at = 8'hDC;  8: exp_at = 8'hF7;
      9: exp_at = 8'hD0;  10: exp_at = 8'hDE; default: exp_at = 8'h80;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_for(input bit r, input bit a, input int prev, input int len);
    if (r) return "R2";
    if (!a) return "R3";
    if (prev == 2 || prev == 8) return "R4";
    if (prev == len - 1) return "R6";
    return "R1";
  endfunction

  task automatic step(input bit r, input bit a);
    int pl, ps;
    logic [7:0] el, es;
    @(negedge clk);
    rst = r; adv = a;
    @(posedge clk);
    #1;
    pl = pos_l; ps = pos_s;
    if (r) begin pos_l = 0; pos_s = 0; end
    else if (a) begin pos_l = (pos_l + 1) % 12; pos_s = (pos_s + 1) % 11; end
    el = exp_at(pos_l); es = exp_at(pos_s);
    check({blue_l, seg_l} == el, tag_for(r, a, pl, 12), {blue_l, seg_l}, el);
    check({blue_s, seg_s} == es, tag_for(r, a, ps, 11), {blue_s, seg_s}, es);
    check((red_l == ~el[7]) && (blue_l == el[7]) && (red_s == ~es[7]) && (blue_s == es[7]),
          "R5", {4'h0, red_l, blue_l, red_s, blue_s}, {4'h0, ~el[7], el[7], ~es[7], es[7]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    step(1'b1, 1'b0);                             // R2 reset state
    step(1'b1, 1'b1);                             // R2 reset beats advance
    for (int i = 0; i < 30; i++) step(1'b0, 1'b1); // R1 R4 R6 R7 two full passes
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0);  // R3 long hold
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1);
    step(1'b1, 1'b1);                             // R2 mid-message reset
    for (int i = 0; i < 400; i++) begin            // random strobes, R3 R4 R6 R7
      int r = $urandom_range(99);
      step(r < 2, r >= 2 && r < 60);
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule